// File: doc/BRIEF.md
# Kick-Driven Watchdog Timer

The block is a watchdog timer controlled through one 8-bit read/write control byte. A 3-bit field in the byte selects one of seven timeout periods or switches the watchdog off. While the watchdog runs, it counts whole milliseconds. Each millisecond is derived from the system clock by a prescaler whose length is a parameter, so a bench can use a short millisecond.

Software restarts the countdown by raising a kick bit in the same byte. A board-level kick pin, passed through a two-flop synchronizer, does the same job. If the selected period elapses without a kick, the block drives a reset pulse of fixed length. It then reloads the countdown and keeps running.

Writes use a single-cycle strobe with the data, and the byte is always visible on the read port. Any write that alters the timeout field restarts the countdown, including a write that leaves the off code.

Top module: `kick_watchdog`

## Requirements
- R1: After `rst_n` is released, the control byte reads 0x00 and `wdReset` is low. The 1 ms period is active, so `wdReset` first rises at the CYCLES_PER_MS-th rising clock edge after release.
- R2: `rdData` always shows all 8 bits of the most recent value written with `wrEn`.
- R3: Bits [2:0] select the period: 0=1 ms, 1=10 ms, 2=30 ms, 4=100 ms, 5=1000 ms, 6=10000 ms, 7=60000 ms. With no further reload, `wdReset` rises exactly period×CYCLES_PER_MS clock edges after the edge that reloaded the countdown.
- R4: Code 3 in bits [2:0] turns the watchdog off. The countdown stops at the write edge and no reset pulse is started while the code is held.
- R5: A write whose bits [2:0] differ from the stored ones reloads the countdown at that write edge with the new period. This includes a write that leaves code 3.
- R6: A write with bit 3 set while the stored bit 3 is 0 reloads the countdown. A write that keeps bit 3 at 1, or clears it, while leaving bits [2:0] unchanged does not reload.
- R7: A rising level on `kickPin` reloads the countdown at the third rising clock edge after the change. Holding the pin high or letting it fall has no further effect.
- R8: Each expiry drives `wdReset` high for exactly PULSE_CYCLES clock cycles, starting at the expiry edge (PULSE_CYCLES must be below CYCLES_PER_MS).
- R9: After an expiry the countdown reloads with the same period by itself, so with no kicks `wdReset` rises repeatedly, once every period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Single-cycle write strobe for the control byte |
| wrData | input | 8 | Value written to the control byte |
| rdData | output | 8 | Current contents of the control byte |
| kickPin | input | 1 | Asynchronous external kick input |
| wdReset | output | 1 | Reset pulse raised on timeout |

## Verification
On every cycle, the assertions check these properties:
- a write is reflected on the read port on the next cycle;
- a register or pin kick always produces a reload strobe;
- a reload puts the new period into the countdown;
- an off code freezes the countdown and blocks a pulse;
- every pulse lasts exactly the configured length.

The exact expiry cycle for each period code can only be shown by the bench's scenarios. So can the difference between a kick-bit rise and writes that repeat or clear the bit, the latency of the pin path, and the back-to-back expiries of a free-running 1 ms setting. The scoreboard predicts each of these cycles from the requirements.

// File: rtl/kick_watchdog_pkg.sv
package kick_watchdog_pkg;

  localparam int MS_W = 16;
  localparam logic [2:0] CODE_OFF = 3'd3;

  typedef struct packed {
    logic            reload;
    logic            enable;
    logic [MS_W-1:0] loadMs;
  } wdStrobe_t;

  function automatic logic [MS_W-1:0] codeToMs(input logic [2:0] code);
    logic [MS_W-1:0] ms;
    case (code)
      3'd0:    ms = MS_W'(1);
      3'd1:    ms = MS_W'(10);
      3'd2:    ms = MS_W'(30);
      3'd4:    ms = MS_W'(100);
      3'd5:    ms = MS_W'(1000);
      3'd6:    ms = MS_W'(10000);
      3'd7:    ms = MS_W'(60000);
      default: ms = MS_W'(1);
    endcase
    return ms;
  endfunction

endpackage

// File: rtl/kick_watchdog_ctrl.sv
module kick_watchdog_ctrl
  import kick_watchdog_pkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       kickPin,
  output logic [7:0] rdData,
  output wdStrobe_t  strb
);

  logic [7:0]          regQ;
  logic [SYNC_DEPTH:0] syncQ;
  logic [2:0]          nextCode;
  logic                fieldChange;
  logic                regKick;
  logic                pinRise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regQ <= 8'h00;
    end else if (wrEn) begin
      regQ <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncQ <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_DEPTH-1:0], kickPin};
    end
  end

  always_comb begin
    nextCode    = wrEn ? wrData[2:0] : regQ[2:0];
    fieldChange = wrEn && (wrData[2:0] != regQ[2:0]);
    regKick     = wrEn && wrData[3] && !regQ[3];
    pinRise     = syncQ[SYNC_DEPTH-1] && !syncQ[SYNC_DEPTH];
    strb.reload = fieldChange || regKick || pinRise;
    strb.enable = (nextCode != CODE_OFF);
    strb.loadMs = codeToMs(nextCode);
  end

  assign rdData = regQ;

  // R2
  readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrEn |=> rdData == $past(wrData));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wrEn |=> $stable(rdData));

  // R6
  reg_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && wrData[3] && !rdData[3]) |-> strb.reload);

  // R7
  pin_kick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncQ[SYNC_DEPTH-1]) |-> strb.reload);

endmodule

// File: rtl/kick_watchdog_datapath.sv
module kick_watchdog_datapath
  import kick_watchdog_pkg::*;
#(
  parameter int CYCLES_PER_MS = 100000,
  parameter int PULSE_CYCLES  = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  wdStrobe_t strb,
  output logic      wdReset
);

  localparam int PRE_W = (CYCLES_PER_MS > 1) ? $clog2(CYCLES_PER_MS) : 1;
  localparam int PUL_W = $clog2(PULSE_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CYCLES_PER_MS - 1);

  logic [PRE_W-1:0] presc;
  logic [MS_W-1:0]  msLeft;
  logic [PUL_W-1:0] pulseLeft;
  logic             msTick;
  logic             expire;

  assign msTick = (presc == PRE_LAST);
  assign expire = strb.enable && !strb.reload && msTick && (msLeft == MS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc  <= '0;
      msLeft <= MS_W'(1);
    end else if (!strb.enable) begin
      presc  <= '0;
    end else if (strb.reload) begin
      presc  <= '0;
      msLeft <= strb.loadMs;
    end else if (msTick) begin
      presc  <= '0;
      msLeft <= expire ? strb.loadMs : msLeft - MS_W'(1);
    end else begin
      presc  <= presc + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseLeft <= '0;
    end else if (expire) begin
      pulseLeft <= PUL_W'(PULSE_CYCLES);
    end else if (pulseLeft != '0) begin
      pulseLeft <= pulseLeft - PUL_W'(1);
    end
  end

  assign wdReset = (pulseLeft != '0);

  logic [15:0] runLen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) runLen <= '0;
    else        runLen <= wdReset ? runLen + 16'd1 : 16'd0;
  end

  // R8
  pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wdReset) |-> runLen == 16'(PULSE_CYCLES));

  // R4
  off_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.enable |=> !$rose(wdReset));

  // R4
  off_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.enable |=> $stable(msLeft));

  // R5
  reload_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.reload && strb.enable) |=> (msLeft == $past(strb.loadMs)) && (presc == '0));

endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import kick_watchdog_pkg::*;
#(
  parameter int CYCLES_PER_MS = 100000,
  parameter int PULSE_CYCLES  = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       kickPin,
  output logic       wdReset
);

  wdStrobe_t strb;

  kick_watchdog_ctrl #(
    .SYNC_DEPTH(2)
  ) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrData (wrData),
    .kickPin(kickPin),
    .rdData (rdData),
    .strb   (strb)
  );

  kick_watchdog_datapath #(
    .CYCLES_PER_MS(CYCLES_PER_MS),
    .PULSE_CYCLES (PULSE_CYCLES)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strb   (strb),
    .wdReset(wdReset)
  );

endmodule

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;

  localparam int CLK_PERIOD = 10;
  localparam int CPM        = 5;
  localparam int PULSE      = 3;
  localparam int WD_LIMIT   = 150000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wrEn;
  logic [7:0] wrData;
  logic [7:0] rdData;
  logic       kickPin;
  logic       wdReset;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  int    expQ[$];
  string tagQ[$];

  kick_watchdog #(
    .CYCLES_PER_MS(CPM),
    .PULSE_CYCLES (PULSE)
  ) u_kick_watchdog (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrEn   (wrEn),
    .wrData (wrData),
    .rdData (rdData),
    .kickPin(kickPin),
    .wdReset(wdReset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Monitor: pops expected rise cycles and measures pulse lengths.
  bit    prevOut = 0;
  int    hiLen   = 0;
  int    expCyc;
  string expTag;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wdReset && !prevOut) begin
        if (expQ.size() == 0) begin
          check(0, "R4 unexpected reset pulse", cyc, -1);
        end else begin
          expCyc = expQ.pop_front();
          expTag = tagQ.pop_front();
          check(cyc == expCyc, expTag, cyc, expCyc);
        end
      end
      if (wdReset) hiLen++;
      else if (prevOut) begin
        check(hiLen == PULSE, "R8 pulse length", hiLen, PULSE);
        hiLen = 0;
      end
      prevOut = wdReset;
    end
  end

  task automatic push(input int c, input string tag);
    expQ.push_back(c);
    tagQ.push_back(tag);
  endtask

  // Called at a negedge; the write takes effect at the next posedge.
  task automatic wr(input logic [7:0] d, output int edgeCyc);
    edgeCyc = cyc + 1;
    wrEn   = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic waitHigh();
    while (!wdReset) @(negedge clk);
  endtask

  task automatic turnOff();
    int e;
    wr(8'h03, e);
    waitCyc(PULSE + 3);
  endtask

  task automatic expireOnce(input logic [7:0] code, input int ms, input string tag);
    int e;
    wr(code, e);
    push(e + ms * CPM, tag);
    waitCyc(1);
    waitHigh();
    turnOff();
  endtask

  initial begin
    int e0;
    int e1;
    int c;
    rst_n = 1'b0; wrEn = 1'b0; wrData = 8'h00; kickPin = 1'b0;
    waitCyc(3);
    check(rdData == 8'h00, "R1 reset register", rdData, 0);
    check(wdReset == 1'b0, "R1 reset output low", wdReset, 0);
    rst_n = 1'b1;
    push(cyc + CPM, "R1 first expiry at 1 ms");
    waitHigh();
    turnOff();
    check(rdData == 8'h03, "R2 readback off code", rdData, 3);

    // R4: off code, no pulse may appear
    waitCyc(300);
    check(wdReset == 1'b0, "R4 off stays quiet", wdReset, 0);

    // R3 / R5: each period code, leaving the off code reloads
    expireOnce(8'h00, 1,     "R3 code0 1ms");
    expireOnce(8'h01, 10,    "R3 code1 10ms");
    expireOnce(8'h02, 30,    "R3 code2 30ms");
    expireOnce(8'h04, 100,   "R3 code4 100ms");
    expireOnce(8'h05, 1000,  "R3 code5 1000ms");
    expireOnce(8'h06, 10000, "R3 code6 10000ms");

    // R3: 60 s code, far beyond the window
    wr(8'h07, e0);
    waitCyc(2000);
    check(wdReset == 1'b0, "R3 code7 no early expiry", wdReset, 0);
    check(rdData == 8'h07, "R2 readback code7", rdData, 7);
    turnOff();

    // R9: free running 1 ms, consecutive expiries
    wr(8'h00, e0);
    push(e0 + CPM,     "R9 expiry 1");
    push(e0 + 2 * CPM, "R9 expiry 2");
    push(e0 + 3 * CPM, "R9 expiry 3");
    while (expQ.size() != 0) @(negedge clk);
    turnOff();

    // R6: register kick bit
    wr(8'h02, e0);
    waitCyc(60);
    wr(8'h0A, e1);
    check(rdData == 8'h0A, "R2 readback kick bit", rdData, 8'h0A);
    waitCyc(40);
    wr(8'h0A, c);
    waitCyc(20);
    wr(8'h02, c);
    check(rdData == 8'h02, "R2 readback kick cleared", rdData, 2);
    push(e1 + 30 * CPM, "R6 register kick reload");
    waitHigh();
    turnOff();

    // R7: pin kick through synchronizer
    wr(8'h02, e0);
    waitCyc(70);
    c = cyc;
    kickPin = 1'b1;
    push(c + 3 + 30 * CPM, "R7 pin kick reload");
    waitCyc(40);
    kickPin = 1'b0;
    waitHigh();
    turnOff();

    // R5: period change mid countdown
    wr(8'h02, e0);
    waitCyc(60);
    wr(8'h01, e1);
    push(e1 + 10 * CPM, "R5 period change reload");
    waitHigh();
    turnOff();

    check(expQ.size() == 0, "R3 all expected expiries seen", expQ.size(), 0);
    check(wdReset == 1'b0, "R4 quiet at end", wdReset, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (WD_LIMIT) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog expired", cyc, WD_LIMIT);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule